// File: doc/BRIEF.md
# PHY Register Handshake Master

This block reaches 16-bit registers inside a PHY that are not memory mapped. A client presents a request strobe with a read/write select, a 16-bit register address and, for writes, 16-bit data. The block then works through a fixed series of handshake phases on a 32-bit control word it drives toward the PHY. It watches the acknowledge bit of a 32-bit status word that comes back.

Every access starts with an address phase. The address is driven alone, then with the capture-address bit, and then alone again. A write continues with a data phase, a write-strobe phase and a final zero word. A read continues with a read-strobe phase, samples the read data while the acknowledge is high, and finishes with a zero word. After each assertion and each release, the block polls the acknowledge for the expected level. Polls are a fixed number of clock cycles apart, and their number is limited. If a wait runs out of polls, the access is aborted with an error.

While an access runs, the block reports busy and ignores new requests. A successful access ends with a one-cycle done pulse. A successful read also updates the read-data output, which otherwise holds its value.

Top module: `phy_hs_master`

## Requirements
- R1: After reset, ctrlWord is 0, busy, done and timeoutErr are low, and rdData is 0.
- R2: ctrlWord bits 15:0 carry the address or data, bit 16 is capture-address, bit 17 is capture-data, bit 18 is the write strobe, bit 19 is the read strobe, and bits 31:20 are always 0. In statWord, bit 16 is the acknowledge and bits 15:0 are the read data.
- R3: Every access begins by driving ctrlWord with these values in turn: addr, then addr with bit 16, then a wait for ack high, then addr again, then a wait for ack low.
- R4: A write continues with data, then data with bit 17 (wait for ack high), then data (wait for ack low), then bit 18 alone (wait for ack high), then data (wait for ack low), and finally 0. The done pulse appears in the same cycle that ctrlWord becomes 0.
- R5: A read continues with bit 19 alone (wait for ack high), at which point statWord[15:0] is sampled. It then drives 0 and waits for ack low. The done pulse and the sampled value on rdData appear together.
- R6: Each wait samples the acknowledge in its first cycle and then once every POLL_CYC cycles, for at most MAX_POLLS samples. The wait ends on the first sample at the expected level.
- R7: When a wait's last allowed sample misses, the access is aborted. timeoutErr pulses for one cycle with no done pulse, and ctrlWord returns to 0 in that same cycle. If the first acknowledge never rises, the pulse comes 3 + (MAX_POLLS-1)*POLL_CYC clock edges after the accepting edge.
- R8: busy is high from the cycle after a request is accepted until the cycle of done or timeoutErr. A request presented while busy is ignored.
- R9: rdData changes only when a read completes successfully. Writes and aborted accesses leave it unchanged.
- R10: At most one of ctrlWord bits 19:16 is set in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, sampled only while idle |
| reqWrite | input | 1 | 1 selects a write, 0 a read |
| reqAddr | input | 16 | PHY register address |
| reqData | input | 16 | Write data |
| statWord | input | 32 | Status word from the PHY: ack in bit 16, read data in 15:0 |
| ctrlWord | output | 32 | Control word toward the PHY |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| rdData | output | 16 | Result of the last successful read |
| timeoutErr | output | 1 | One-cycle pulse when an access is aborted |

## Verification
The embedded properties make no assumption about the acknowledge bit: its timing and level may be anything, and the properties still hold. They do assume that reqAddr, reqData and reqWrite are meaningful only in the cycle the request is accepted. The stimulus changes its requests only at the falling edge. It drives the acknowledge from a small PHY model that echoes any raised strobe after three cycles. The model can also be forced stuck low or stuck high, which pushes a wait into its poll limit without breaking any other input rule.

// File: rtl/phy_hs_pkg.sv
package phy_hs_pkg;

  localparam int FIELD_W  = 16;
  localparam int WORD_W   = 32;
  localparam int CAPA_BIT = 16;
  localparam int CAPD_BIT = 17;
  localparam int WSTB_BIT = 18;
  localparam int RSTB_BIT = 19;
  localparam int ACK_BIT  = 16;

  typedef enum logic [2:0] {
    W_ZERO, W_ADDR, W_ADDR_CAPA, W_DATA, W_DATA_CAPD, W_WRSTB, W_RDSTB
  } wordSel_e;

  typedef enum logic [4:0] {
    S_IDLE,
    S_A_ADDR, S_A_CAPA, S_A_WHI, S_A_REL, S_A_WLO,
    S_W_DATA, S_W_CAPD, S_W_DHI, S_W_DREL, S_W_DLO,
    S_W_STB, S_W_SHI, S_W_SREL, S_W_SLO, S_W_ZERO,
    S_R_STB, S_R_WHI, S_R_ZERO, S_R_WLO
  } step_e;

  typedef struct packed {
    logic     latchReq;
    logic     loadWord;
    wordSel_e wordSel;
    logic     waitAck;
    logic     ackLevel;
    logic     captureRd;
    logic     commitRd;
  } hsStrobe_t;

endpackage

// File: rtl/phy_hs_dpath.sv
module phy_hs_dpath
  import phy_hs_pkg::*;
#(
  parameter int POLL_CYC  = 100,
  parameter int MAX_POLLS = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  hsStrobe_t           hs,
  input  logic [FIELD_W-1:0]  reqAddr,
  input  logic [FIELD_W-1:0]  reqData,
  input  logic [WORD_W-1:0]   statWord,
  output logic [WORD_W-1:0]   ctrlWord,
  output logic [FIELD_W-1:0]  rdData,
  output logic                pollHit,
  output logic                pollExpire
);

  localparam int PCNT_W = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
  localparam logic [PCNT_W-1:0] LAST_POLL = PCNT_W'(MAX_POLLS - 1);

  logic [FIELD_W-1:0] addrQ;
  logic [FIELD_W-1:0] dataQ;
  logic [FIELD_W-1:0] pendRd;
  logic [WORD_W-1:0]  wordMux;
  logic [PCNT_W-1:0]  pollCnt;
  logic               gapZero;
  logic               pollNow;
  logic               ackSeen;
  logic               unusedStatHi;

  assign unusedStatHi = ^statWord[WORD_W-1:ACK_BIT+1];

  // request capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrQ <= '0;
      dataQ <= '0;
    end else if (hs.latchReq) begin
      addrQ <= reqAddr;
      dataQ <= reqData;
    end
  end

  // control word composition
  always_comb begin
    wordMux = '0;
    case (hs.wordSel)
      W_ADDR:      wordMux[FIELD_W-1:0] = addrQ;
      W_ADDR_CAPA: begin
        wordMux[FIELD_W-1:0] = addrQ;
        wordMux[CAPA_BIT]    = 1'b1;
      end
      W_DATA:      wordMux[FIELD_W-1:0] = dataQ;
      W_DATA_CAPD: begin
        wordMux[FIELD_W-1:0] = dataQ;
        wordMux[CAPD_BIT]    = 1'b1;
      end
      W_WRSTB:     wordMux[WSTB_BIT] = 1'b1;
      W_RDSTB:     wordMux[RSTB_BIT] = 1'b1;
      default:     wordMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrlWord <= '0;
    else if (hs.loadWord) ctrlWord <= wordMux;
  end

  // poll spacing: a variant without a gap counter when every cycle polls
  generate
    if (POLL_CYC > 1) begin : g_gap
      localparam int GAP_W = $clog2(POLL_CYC);
      logic [GAP_W-1:0] gapCnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gapCnt <= '0;
        else if (!hs.waitAck || pollHit || pollExpire) gapCnt <= '0;
        else if (gapZero) gapCnt <= GAP_W'(POLL_CYC - 1);
        else gapCnt <= gapCnt - 1'b1;
      end
      assign gapZero = (gapCnt == '0);
    end else begin : g_nogap
      assign gapZero = 1'b1;
    end
  endgenerate

  assign pollNow    = hs.waitAck && gapZero;
  assign ackSeen    = (statWord[ACK_BIT] == hs.ackLevel);
  assign pollHit    = pollNow && ackSeen;
  assign pollExpire = pollNow && !ackSeen && (pollCnt == LAST_POLL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pollCnt <= '0;
    else if (!hs.waitAck || pollHit || pollExpire) pollCnt <= '0;
    else if (pollNow) pollCnt <= pollCnt + 1'b1;
  end

  // read result: sampled mid-access, published only on completion
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendRd <= '0;
      rdData <= '0;
    end else begin
      if (hs.captureRd) pendRd <= statWord[FIELD_W-1:0];
      if (hs.commitRd)  rdData <= pendRd;
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctrlWord[RSTB_BIT:CAPA_BIT])); // R10

  AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlWord[WORD_W-1:RSTB_BIT+1] == '0); // R2

  AST_POLL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    pollCnt <= LAST_POLL); // R6

  AST_NO_WAIT_NO_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    !hs.waitAck |=> pollCnt == '0); // R6

endmodule

// File: rtl/phy_hs_ctrl.sv
module phy_hs_ctrl
  import phy_hs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      reqValid,
  input  logic      reqWrite,
  input  logic      pollHit,
  input  logic      pollExpire,
  output hsStrobe_t hs,
  output logic      busy,
  output logic      done,
  output logic      timeoutErr
);

  step_e state;
  step_e nxt;
  step_e hitNext;
  logic  opWrite;
  logic  doneNxt;
  logic  errNxt;

  always_comb begin
    hs         = '0;
    hs.wordSel = W_ZERO;
    nxt        = state;
    hitNext    = state;
    doneNxt    = 1'b0;
    errNxt     = 1'b0;
    case (state)
      S_IDLE: if (reqValid) begin
        hs.latchReq = 1'b1;
        nxt         = S_A_ADDR;
      end
      // address phase
      S_A_ADDR: begin hs.loadWord = 1'b1; hs.wordSel = W_ADDR;      nxt = S_A_CAPA; end
      S_A_CAPA: begin hs.loadWord = 1'b1; hs.wordSel = W_ADDR_CAPA; nxt = S_A_WHI;  end
      S_A_WHI:  begin hs.waitAck = 1'b1; hs.ackLevel = 1'b1; hitNext = S_A_REL; end
      S_A_REL:  begin hs.loadWord = 1'b1; hs.wordSel = W_ADDR;      nxt = S_A_WLO;  end
      S_A_WLO:  begin
        hs.waitAck = 1'b1;
        hitNext    = opWrite ? S_W_DATA : S_R_STB;
      end
      // write: data capture
      S_W_DATA: begin hs.loadWord = 1'b1; hs.wordSel = W_DATA;      nxt = S_W_CAPD; end
      S_W_CAPD: begin hs.loadWord = 1'b1; hs.wordSel = W_DATA_CAPD; nxt = S_W_DHI;  end
      S_W_DHI:  begin hs.waitAck = 1'b1; hs.ackLevel = 1'b1; hitNext = S_W_DREL; end
      S_W_DREL: begin hs.loadWord = 1'b1; hs.wordSel = W_DATA;      nxt = S_W_DLO;  end
      S_W_DLO:  begin hs.waitAck = 1'b1; hitNext = S_W_STB; end
      // write: strobe
      S_W_STB:  begin hs.loadWord = 1'b1; hs.wordSel = W_WRSTB;     nxt = S_W_SHI;  end
      S_W_SHI:  begin hs.waitAck = 1'b1; hs.ackLevel = 1'b1; hitNext = S_W_SREL; end
      S_W_SREL: begin hs.loadWord = 1'b1; hs.wordSel = W_DATA;      nxt = S_W_SLO;  end
      S_W_SLO:  begin hs.waitAck = 1'b1; hitNext = S_W_ZERO; end
      S_W_ZERO: begin
        hs.loadWord = 1'b1;
        hs.wordSel  = W_ZERO;
        nxt         = S_IDLE;
        doneNxt     = 1'b1;
      end
      // read
      S_R_STB:  begin hs.loadWord = 1'b1; hs.wordSel = W_RDSTB;     nxt = S_R_WHI;  end
      S_R_WHI:  begin
        hs.waitAck   = 1'b1;
        hs.ackLevel  = 1'b1;
        hs.captureRd = pollHit;
        hitNext      = S_R_ZERO;
      end
      S_R_ZERO: begin hs.loadWord = 1'b1; hs.wordSel = W_ZERO;      nxt = S_R_WLO;  end
      S_R_WLO:  begin
        hs.waitAck  = 1'b1;
        hs.commitRd = pollHit;
        hitNext     = S_IDLE;
        doneNxt     = pollHit;
      end
      default:  nxt = S_IDLE;
    endcase

    if (hs.waitAck) begin
      if (pollHit) begin
        nxt = hitNext;
      end else if (pollExpire) begin
        hs.loadWord = 1'b1;
        hs.wordSel  = W_ZERO;
        nxt         = S_IDLE;
        errNxt      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      opWrite    <= 1'b0;
      done       <= 1'b0;
      timeoutErr <= 1'b0;
    end else begin
      state      <= nxt;
      done       <= doneNxt;
      timeoutErr <= errNxt;
      if (hs.latchReq) opWrite <= reqWrite;
    end
  end

  assign busy = (state != S_IDLE);

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && reqValid) |=> busy); // R8

  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R8

  AST_ERR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    timeoutErr |-> (!busy && $past(busy))); // R7

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeoutErr)); // R7

endmodule

// File: rtl/phy_hs_master.sv
module phy_hs_master
  import phy_hs_pkg::*;
#(
  parameter int CLK_MHZ   = 100,
  parameter int POLL_CYC  = CLK_MHZ,
  parameter int MAX_POLLS = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [15:0] reqAddr,
  input  logic [15:0] reqData,
  input  logic [31:0] statWord,
  output logic [31:0] ctrlWord,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdData,
  output logic        timeoutErr
);

  hsStrobe_t hs;
  logic      pollHit;
  logic      pollExpire;

  phy_hs_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .pollHit    (pollHit),
    .pollExpire (pollExpire),
    .hs         (hs),
    .busy       (busy),
    .done       (done),
    .timeoutErr (timeoutErr)
  );

  phy_hs_dpath #(
    .POLL_CYC  (POLL_CYC),
    .MAX_POLLS (MAX_POLLS)
  ) u_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .hs         (hs),
    .reqAddr    (reqAddr),
    .reqData    (reqData),
    .statWord   (statWord),
    .ctrlWord   (ctrlWord),
    .rdData     (rdData),
    .pollHit    (pollHit),
    .pollExpire (pollExpire)
  );

  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    timeoutErr |-> ctrlWord == '0); // R7

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ctrlWord == '0); // R4

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rdData != $past(rdData)) |-> done); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> ctrlWord == '0); // R3

endmodule

// File: tb/phy_hs_master_test.sv
module phy_hs_master_test;

  localparam int GAP = 4;
  localparam int NPOLL = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [15:0] reqData = '0;
  logic [31:0] statWord;
  logic [31:0] ctrlWord;
  logic        busy;
  logic        done;
  logic [15:0] rdData;
  logic        timeoutErr;

  always #5 clk = ~clk;

  phy_hs_master #(.POLL_CYC(GAP), .MAX_POLLS(NPOLL)) uut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqData(reqData), .statWord(statWord),
    .ctrlWord(ctrlWord), .busy(busy), .done(done), .rdData(rdData),
    .timeoutErr(timeoutErr)
  );

  // PHY model: ack echoes any raised strobe after three cycles
  int          phyMode = 0; // 0 normal, 1 stuck low, 2 stuck high
  logic [2:0]  ackPipe;
  logic [15:0] phyMem [16];
  logic [15:0] latAddr;
  logic [15:0] latData;
  logic        ackBit;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ackPipe <= '0;
      latAddr <= '0;
      latData <= '0;
      for (int i = 0; i < 16; i++) phyMem[i] <= 16'hA000 + 16'(i);
    end else begin
      ackPipe <= {ackPipe[1:0], |ctrlWord[19:16]};
      if (ctrlWord[16]) latAddr <= ctrlWord[15:0];
      if (ctrlWord[17]) latData <= ctrlWord[15:0];
      if (ctrlWord[18]) phyMem[latAddr[3:0]] <= latData;
    end
  end

  assign ackBit   = (phyMode == 0) ? ackPipe[2] : (phyMode == 2);
  assign statWord = {15'b0, ackBit, phyMem[latAddr[3:0]]};

  // scoreboard
  typedef struct {
    int          kind; // 0 write, 1 read, 2 abort
    logic [31:0] sig;
    logic [15:0] rd;
  } exp_t;

  exp_t        expQ[$];
  logic [15:0] shadow [16];
  int          nChecks = 0;
  int          nFail = 0;
  int          nDone = 0;
  bit          strobeBad = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] sigStep(input logic [31:0] s, input logic [31:0] w);
    return {s[30:0], s[31]} ^ w;
  endfunction

  // monitor
  initial begin
    logic [31:0] prevW;
    logic [31:0] sig;
    exp_t        e;
    prevW = '0;
    sig   = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (ctrlWord !== prevW) begin
          sig   = sigStep(sig, ctrlWord);
          prevW = ctrlWord;
        end
        if (ctrlWord[31:20] != 0 || $countones(ctrlWord[19:16]) > 1) strobeBad = 1;
        if (done || timeoutErr) begin
          nDone++;
          if (expQ.size() == 0) begin
            chk("R8", "unexpected completion", 32'(done), 32'h0);
          end else begin
            e = expQ.pop_front();
            chk("R7", "outcome is error", 32'(timeoutErr), 32'(e.kind == 2));
            chk("R2 R3 R4 R5", "control word sequence", sig, e.sig);
            if (e.kind == 1) chk("R5", "read data", 32'(rdData), 32'(e.rd));
          end
          sig = '0;
        end
      end
    end
  end

  // builds the expected control-word sequence signature
  function automatic logic [31:0] expSig(input int kind, input logic [15:0] a,
                                         input logic [15:0] d);
    logic [31:0] s;
    s = sigStep(32'h0, {16'h0, a});
    s = sigStep(s, {16'h1, a});
    if (kind == 2) return sigStep(s, 32'h0);          // stalled at first ack
    s = sigStep(s, {16'h0, a});
    if (kind == 3) return sigStep(s, 32'h0);          // stalled at ack release
    if (kind == 0) begin
      s = sigStep(s, {16'h0, d});
      s = sigStep(s, {16'h2, d});
      s = sigStep(s, {16'h0, d});
      s = sigStep(s, 32'h0004_0000);
      s = sigStep(s, {16'h0, d});
    end else begin
      s = sigStep(s, 32'h0008_0000);
    end
    return sigStep(s, 32'h0);
  endfunction

  // driver: kind 0 write, 1 read, 2/3 aborted
  task automatic doAccess(input bit wr, input logic [15:0] a, input logic [15:0] d,
                          input int kind, input bit poke);
    exp_t e;
    while (busy) @(negedge clk);
    e.kind = (kind >= 2) ? 2 : kind;
    e.sig  = expSig(kind, a, d);
    e.rd   = shadow[a[3:0]];
    expQ.push_back(e);
    reqWrite = wr; reqAddr = a; reqData = d; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R8", "busy after accept", 32'(busy), 32'h1);
    if (poke) begin
      reqValid = 1'b1; reqWrite = ~wr; reqAddr = a ^ 16'h0f0f; reqData = ~d;
      @(negedge clk);
      reqValid = 1'b0;
    end
    while (busy) @(negedge clk);
    @(negedge clk);
    if (kind == 0) shadow[a[3:0]] = d;
  endtask

  // watchdog
  initial begin
    #2000000;
    nChecks++;
    nFail++;
    $display("FAIL R8 watchdog actual=hung expected=idle");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    logic [15:0] held;
    int          n;
    for (int i = 0; i < 16; i++) shadow[i] = 16'hA000 + 16'(i);
    repeat (3) @(negedge clk);
    chk("R1", "ctrlWord in reset", ctrlWord, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ctrlWord after reset", ctrlWord, 32'h0);
    chk("R1", "busy after reset", 32'(busy), 32'h0);
    chk("R1", "done after reset", 32'(done), 32'h0);
    chk("R1", "timeoutErr after reset", 32'(timeoutErr), 32'h0);
    chk("R1", "rdData after reset", 32'(rdData), 32'h0);

    doAccess(1'b1, 16'h0011, 16'h1234, 0, 1'b0);
    chk("R9", "rdData after write", 32'(rdData), 32'h0);
    doAccess(1'b1, 16'h0022, 16'hBEEF, 0, 1'b0);
    doAccess(1'b0, 16'h0011, 16'h0, 1, 1'b0);
    doAccess(1'b0, 16'h0022, 16'h0, 1, 1'b0);
    doAccess(1'b0, 16'h0033, 16'h0, 1, 1'b0);
    held = rdData;
    doAccess(1'b1, 16'h0044, 16'h5A5A, 0, 1'b1);
    chk("R9", "rdData held across write", 32'(rdData), 32'(held));
    doAccess(1'b0, 16'h0044, 16'h0, 1, 1'b1);
    chk("R8", "one completion per accepted request", 32'(nDone), 32'd7);

    // abort timing with ack stuck low
    phyMode = 1;
    repeat (5) @(negedge clk);
    held = rdData;
    begin
      exp_t e;
      e.kind = 2; e.sig = expSig(2, 16'h0055, 16'h7777); e.rd = '0;
      expQ.push_back(e);
    end
    reqWrite = 1'b1; reqAddr = 16'h0055; reqData = 16'h7777; reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    n = 0;
    while (!timeoutErr && n < 500) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
    chk("R6 R7", "edges to abort", 32'(n), 32'(3 + (NPOLL - 1) * GAP));
    chk("R7", "ctrlWord zero on abort", ctrlWord, 32'h0);
    chk("R7", "done absent on abort", 32'(done), 32'h0);
    chk("R7", "busy low on abort", 32'(busy), 32'h0);
    @(negedge clk);
    chk("R7", "error is one pulse", 32'(timeoutErr), 32'h0);
    chk("R9", "rdData held after abort", 32'(rdData), 32'(held));

    // abort in the release wait with ack stuck high
    phyMode = 2;
    repeat (5) @(negedge clk);
    doAccess(1'b0, 16'h0011, 16'h0, 3, 1'b0);
    chk("R9", "rdData held after aborted read", 32'(rdData), 32'(held));

    phyMode = 0;
    repeat (5) @(negedge clk);
    doAccess(1'b0, 16'h0055, 16'h0, 1, 1'b0);
    chk("R7", "aborted write left register", 32'(rdData), 32'hA005);
    doAccess(1'b0, 16'h0011, 16'h0, 1, 1'b0);

    repeat (10) @(negedge clk);
    chk("R10", "single strobe bit at a time", 32'(strobeBad), 32'h0);
    chk("R8", "no pending expectation", 32'(expQ.size()), 32'h0);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule